// File: doc/BRIEF.md
# Power-Manager Reset Sequencer

This block owns the reset behaviour of a small power-management controller. Two events can reset the controller's configuration. The first is a host write that sets a self-clearing soft-reset bit. The second is an undervoltage flag from the analog supply monitor. On either event the block drops every regulator enable and every general-purpose output at once and forces the configuration registers back to their built-in defaults. It then runs a request/done handshake with the one-time-programmable store, which writes its values into the registers.

The two paths end differently. A soft reset returns to normal running once the reload is done, and the host bus logic keeps working throughout. Recovery from undervoltage is treated as a power-on reset: the registers are cleared, the reload runs, and then a one-cycle startup request is issued before normal running resumes. Host writes take effect only in normal running. The undervoltage input is synchronised through a chain of flops. Controller reset behaves as if the supply were low.

Top module: `pm_reset_seq`

## Requirements
- R1: The `uvlo` input passes through SYNC_STAGES (2) flops. From the third rising edge after `uvlo` goes high, `reg_en` and `gpo` are all zero, and they stay zero while it is high.
- R2: While the synchronised undervoltage flag is high, every register reads back its default value, from the fourth rising edge after `uvlo` rises.
- R3: Register i has the default value (37*i + 5) mod 2^DATA_W. With DATA_W=8 these are 0x05, 0x2A and 0x4F for i = 0, 1 and 2.
- R4: A write in normal running to address NUM_CFG-1 with data bit 0 set is a soft reset. Outputs go low from the next edge, registers hold their defaults from the second edge, and `otp_req` is high from the second edge.
- R5: Address NUM_CFG-1 holds no storage and always reads 0. A write there with bit 0 clear has no effect.
- R6: `otp_req` stays high until `otp_done` is sampled. While it is high, `otp_wr` writes `otp_data` to `otp_addr`, except at address NUM_CFG-1.
- R7: Host writes are ignored in every state other than normal running, including during the OTP load.
- R8: A soft reset never raises `start_req`. The block returns to normal running on the edge that samples `otp_done`.
- R9: After the synchronised flag falls, the block clears the registers for one cycle and then runs the OTP load. After `otp_done` it raises `start_req` for exactly one cycle and then resumes normal running.
- R10: If the synchronised flag is high in the same cycle that a soft-reset write arrives, the undervoltage hold wins and no OTP load starts while the flag stays high.
- R11: In normal running and in the startup cycle, `reg_en` equals register 0 bits [NUM_REG-1:0] and `gpo` equals register 1 bits [NUM_GPO-1:0]. In all other states both are zero.
- R12: While `rst` is high and after it is released, the block behaves as if undervoltage were present until the synchronised input has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo | input | 1 | Asynchronous undervoltage flag from supply monitor |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Readback address |
| rd_data | output | DATA_W | Readback data |
| otp_req | output | 1 | OTP load request, held until done |
| otp_wr | input | 1 | OTP word write strobe |
| otp_addr | input | ADDR_W | OTP word target address |
| otp_data | input | DATA_W | OTP word value |
| otp_done | input | 1 | OTP load finished |
| reg_en | output | NUM_REG | Regulator enables |
| gpo | output | NUM_GPO | General-purpose outputs |
| start_req | output | 1 | One-cycle startup request |

## Verification
The bench builds the block with its defaults: NUM_CFG=4 and DATA_W=8, two regulators, two GPOs, and a two-stage synchroniser. With these values every register, including the storage-free reset address, can be swept by the readback port on consecutive cycles. The short synchroniser also makes it possible to time a soft-reset write onto the exact cycle the synchronised flag rises, which tests the priority rule. Distinct non-zero defaults make a cleared register easy to tell apart from one that OTP or the host has rewritten.

// File: rtl/pm_rst_pkg.sv
package pm_rst_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_CLEAR,
        ST_OTP_LOAD,
        ST_START,
        ST_UVLO_HOLD
    } seq_state_e;

    typedef struct packed {
        logic clear;    // force registers to defaults
        logic host_ok;  // host writes accepted
        logic otp_ok;   // OTP writes accepted
        logic active;   // enables and GPOs follow registers
    } seq_ctrl_t;

    localparam int unsigned DEF_MUL = 37;
    localparam int unsigned DEF_ADD = 5;

    function automatic logic [31:0] cfg_default(input int unsigned idx);
        return 32'(idx * DEF_MUL + DEF_ADD);
    endfunction

    function automatic seq_ctrl_t ctrl_of(input seq_state_e s);
        seq_ctrl_t c;
        c.clear   = (s == ST_CLEAR) || (s == ST_UVLO_HOLD);
        c.host_ok = (s == ST_RUN);
        c.otp_ok  = (s == ST_OTP_LOAD);
        c.active  = (s == ST_RUN) || (s == ST_START);
        return c;
    endfunction

endpackage

// File: rtl/pm_uvlo_sync.sv
module pm_uvlo_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[LAST];
endmodule

// File: rtl/pm_rst_fsm.sv
module pm_rst_fsm
    import pm_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       uvlo_s,
    input  logic       soft_req,
    input  logic       otp_done,
    output seq_state_e state,
    output seq_ctrl_t  ctrl
);
    seq_state_e state_q, state_d;
    logic       pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        if (uvlo_s) begin
            state_d = ST_UVLO_HOLD;
        end else begin
            unique case (state_q)
                ST_RUN: if (soft_req) begin
                    state_d = ST_CLEAR;
                    pend_d  = 1'b0;
                end
                ST_CLEAR:     state_d = ST_OTP_LOAD;
                ST_OTP_LOAD:  if (otp_done) state_d = pend_q ? ST_START : ST_RUN;
                ST_START: begin
                    state_d = ST_RUN;
                    pend_d  = 1'b0;
                end
                ST_UVLO_HOLD: begin
                    state_d = ST_CLEAR;
                    pend_d  = 1'b1;
                end
                default:      state_d = ST_UVLO_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UVLO_HOLD;
            pend_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign state = state_q;
    assign ctrl  = ctrl_of(state_q);

    // R10
    uvlo_prio_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo_s |=> state_q == ST_UVLO_HOLD);

    // R4
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && soft_req && !uvlo_s) |=> state_q == ST_CLEAR);

    // R8
    soft_nostart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OTP_LOAD && otp_done && !pend_q && !uvlo_s) |=> state_q == ST_RUN);
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_rst_pkg::*;
#(
    parameter int NUM_CFG = 4,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = $clog2(NUM_CFG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              otp_we,
    input  logic [ADDR_W-1:0] otp_addr,
    input  logic [DATA_W-1:0] otp_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] en_reg,
    output logic [DATA_W-1:0] gpo_reg
);
    localparam int RST_IDX = NUM_CFG - 1;

    logic [NUM_CFG-1:0][DATA_W-1:0] mem;

    generate
        for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
            if (g == RST_IDX) begin : g_ctl
                assign mem[g] = '0;
            end else begin : g_store
                always_ff @(posedge clk) begin
                    if (rst || clear)
                        mem[g] <= DATA_W'(cfg_default(g));
                    else if (otp_we && otp_addr == ADDR_W'(g))
                        mem[g] <= otp_data;
                    else if (host_we && host_addr == ADDR_W'(g))
                        mem[g] <= host_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_CFG) rd_data = mem[rd_addr];
    end

    assign en_reg  = mem[0];
    assign gpo_reg = mem[1];

    // R7
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(clear || otp_we || host_we) |=> $stable(mem));

    // R5
    ctl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(RST_IDX)) |-> rd_data == '0);
endmodule

// File: rtl/pm_reset_seq.sv
module pm_reset_seq
    import pm_rst_pkg::*;
#(
    parameter int NUM_CFG     = 4,
    parameter int DATA_W      = 8,
    parameter int NUM_REG     = 2,
    parameter int NUM_GPO     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_CFG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               uvlo,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               otp_req,
    input  logic               otp_wr,
    input  logic [ADDR_W-1:0]  otp_addr,
    input  logic [DATA_W-1:0]  otp_data,
    input  logic               otp_done,
    output logic [NUM_REG-1:0] reg_en,
    output logic [NUM_GPO-1:0] gpo,
    output logic               start_req
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CFG - 1);

    logic        uvlo_s;
    logic        soft_req;
    seq_state_e  state;
    seq_ctrl_t   ctrl;
    logic [DATA_W-1:0] en_reg, gpo_reg;

    pm_uvlo_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(uvlo), .q(uvlo_s)
    );

    assign soft_req = wr_en && (wr_addr == CTL_ADDR) && wr_data[0];

    pm_rst_fsm u_fsm (
        .clk(clk), .rst(rst), .uvlo_s(uvlo_s), .soft_req(soft_req),
        .otp_done(otp_done), .state(state), .ctrl(ctrl)
    );

    pm_cfg_regs #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .clear(ctrl.clear),
        .host_we(ctrl.host_ok && wr_en), .host_addr(wr_addr), .host_data(wr_data),
        .otp_we(ctrl.otp_ok && otp_wr), .otp_addr(otp_addr), .otp_data(otp_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .en_reg(en_reg), .gpo_reg(gpo_reg)
    );

    assign reg_en    = ctrl.active ? en_reg[NUM_REG-1:0]  : '0;
    assign gpo       = ctrl.active ? gpo_reg[NUM_GPO-1:0] : '0;
    assign otp_req   = ctrl.otp_ok;
    assign start_req = (state == ST_START);

    // R1
    uvlo_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        $past(uvlo_s) |-> (reg_en == '0 && gpo == '0));

    // R9
    start_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        start_req |-> $past(otp_done));

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_req |=> !start_req);
endmodule

// File: tb/pm_reset_seq_bench.sv
module pm_reset_seq_bench;
    localparam int NC = 4, DW = 8, NR = 2, NG = 2, AW = 2;
    localparam int CTL = NC - 1;

    logic clk = 0, rst = 1, uvlo = 1;
    logic wr_en = 0, otp_wr = 0, otp_done = 0;
    logic [AW-1:0] wr_addr = 0, rd_addr = 0, otp_addr = 0;
    logic [DW-1:0] wr_data = 0, otp_data = 0;
    logic [DW-1:0] rd_data;
    logic otp_req, start_req;
    logic [NR-1:0] reg_en;
    logic [NG-1:0] gpo;

    int tests = 0, fails = 0;
    bit done = 0;
    int start_seen = 0;

    always #5 clk = ~clk;

    pm_reset_seq u_pm_reset_seq (
        .clk(clk), .rst(rst), .uvlo(uvlo), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .otp_req(otp_req),
        .otp_wr(otp_wr), .otp_addr(otp_addr), .otp_data(otp_data), .otp_done(otp_done),
        .reg_en(reg_en), .gpo(gpo), .start_req(start_req)
    );

    // behavioural reference: phase 0 run,1 clear,2 load,3 start,4 hold
    int phase;
    bit pend;
    bit syncq[$];
    logic [DW-1:0] mm [NC];

    function automatic logic [DW-1:0] dflt(int i);
        return DW'(37 * i + 5);
    endfunction

    always @(posedge clk) begin
        int np;
        bit s2;
        if (rst) begin
            syncq = '{1, 1};
            phase = 4; pend = 1;
            for (int i = 0; i < NC; i++) mm[i] = dflt(i);
        end else begin
            s2 = syncq[1];
            if (phase == 1 || phase == 4)
                for (int i = 0; i < NC; i++) mm[i] = dflt(i);
            else if (phase == 2 && otp_wr) begin
                if (otp_addr != CTL) mm[otp_addr] = otp_data;
            end else if (phase == 0 && wr_en && wr_addr != CTL)
                mm[wr_addr] = wr_data;
            np = phase;
            if (s2) np = 4;
            else if (phase == 0 && wr_en && wr_addr == CTL && wr_data[0]) begin np = 1; pend = 0; end
            else if (phase == 1) np = 2;
            else if (phase == 2 && otp_done) np = pend ? 3 : 0;
            else if (phase == 3) begin np = 0; pend = 0; end
            else if (phase == 4) begin np = 1; pend = 1; end
            phase = np;
            syncq.push_front(uvlo);
            void'(syncq.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit act;
            logic [DW-1:0] er;
            act = (phase == 0 || phase == 3);
            er = (rd_addr == CTL) ? '0 : mm[rd_addr];
            chk(reg_en == (act ? mm[0][NR-1:0] : '0), "R1 R11 reg_en", reg_en, act ? mm[0][NR-1:0] : 0);
            chk(gpo == (act ? mm[1][NG-1:0] : '0), "R1 R11 gpo", gpo, act ? mm[1][NG-1:0] : 0);
            chk(rd_data == er, "R2 R6 rd_data", rd_data, er);
            chk(otp_req == (phase == 2), "R6 otp_req", otp_req, phase == 2);
            chk(start_req == (phase == 3), "R9 start_req", start_req, phase == 3);
            if (start_req) start_seen++;
        end
    end

    always @(posedge clk) #1 rd_addr <= rd_addr + 1'b1;

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host_wr(input int a, input int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
        tick();
        wr_en = 0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20 && !otp_req; i++) tick();
    endtask

    task automatic finish_load();
        otp_done = 1; tick(); otp_done = 0;
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick(2);
        @(negedge clk);
        // R12: still held after reset
        chk(reg_en == 0 && otp_req == 0, "R12 held after reset", {reg_en, otp_req}, 0);
        tick();
        uvlo = 0;
        wait_req();
        @(negedge clk);
        chk(otp_req == 1, "R9 load after recovery", otp_req, 1);
        for (int i = 0; i < NC; i++) chk(mm[i] == ((i == CTL) ? mm[i] : dflt(i)), "R3 defaults", mm[i], dflt(i));
        tick();
        // R7: host write during load ignored
        host_wr(2, 'h99);
        otp_wr = 1; otp_addr = 0; otp_data = 'h03; tick();
        otp_addr = 1; otp_data = 'h01; tick();
        otp_addr = AW'(CTL); otp_data = 'hFF; tick();
        otp_wr = 0;
        start_seen = 0;
        finish_load();
        tick(2);
        @(negedge clk);
        chk(start_seen == 1, "R9 one start pulse", start_seen, 1);
        chk(reg_en == 2'b11 && gpo == 2'b01, "R11 loaded outputs", {reg_en, gpo}, 4'b1101);
        chk(mm[2] == dflt(2), "R7 write during load ignored", mm[2], dflt(2));
        tick();
        host_wr(2, 'h77);
        host_wr(0, 'h02);
        host_wr(CTL, 'h00);
        tick();
        @(negedge clk);
        chk(reg_en == 2'b10 && otp_req == 0, "R5 clear bit no reset", {reg_en, otp_req}, 3'b100);
        tick();
        // R4 soft reset
        start_seen = 0;
        host_wr(CTL, 'h01);
        @(negedge clk);
        chk(reg_en == 0 && gpo == 0, "R4 outputs low", {reg_en, gpo}, 0);
        tick();
        @(negedge clk);
        chk(otp_req == 1, "R4 load requested", otp_req, 1);
        chk(mm[2] == dflt(2), "R4 registers default", mm[2], dflt(2));
        tick(2);
        finish_load();
        tick(2);
        @(negedge clk);
        chk(start_seen == 0, "R8 no start after soft reset", start_seen, 0);
        chk(reg_en == dflt(0)[NR-1:0] && otp_req == 0, "R8 back to run", reg_en, dflt(0)[NR-1:0]);
        tick();
        // R10 priority
        uvlo = 1;
        tick(2);
        host_wr(CTL, 'h01);
        @(negedge clk);
        chk(reg_en == 0 && gpo == 0, "R1 outputs low on uvlo", {reg_en, gpo}, 0);
        tick(3);
        @(negedge clk);
        chk(otp_req == 0, "R10 hold wins over soft reset", otp_req, 0);
        tick();
        host_wr(2, 'h55);
        tick();
        @(negedge clk);
        chk(mm[2] == dflt(2), "R2 registers at default in hold", mm[2], dflt(2));
        start_seen = 0;
        uvlo = 0;
        wait_req();
        tick(2);
        finish_load();
        tick(2);
        @(negedge clk);
        chk(start_seen == 1, "R9 start after second recovery", start_seen, 1);
        tick(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule